// File: doc/BRIEF.md
# DMA Request Handshake Controller

This block drives the request line of an asynchronous peripheral DMA channel that moves 16-bit words between an external bus master and one endpoint buffer of a USB function controller. Software sets the mode in an 8-bit configuration register, may preload a 32-bit byte counter, and then pulses `start`. The bus master answers each request by moving one word and pulsing `word_done`. The controller counts bytes and raises or drops `dma_req` based on the handshake mode and the room the endpoint reports.

There are two counting schemes. In free-run mode the counter counts up the bytes moved until software issues `stop`. In count-down mode the counter holds the bytes still to go, and the transfer ends by itself with a one-cycle `xfer_done` pulse. An optional receive-limit mode is used on endpoint writes. It drops the request while 32 bytes of space are still free, so that words already in flight upstream can still land. Words that complete after the request has dropped are still accepted and counted.

Top module: `dmahs_ctrl`

## Requirements
- R1: The configuration register holds receive-limit enable at bit 7, single-word select at bit 3 and count-down select at bit 0. Bits 6..4 and 2..1 always read 0. All bits reset to 0, so the readback equals the written value ANDed with 0x89.
- R2: After reset, and at any time while the controller is idle, `dma_req` is 0 and `xfer_done` is 0. Word strobes while idle leave the counter unchanged.
- R3: A `start` pulse while idle makes the controller active. `dma_req` is 1 in the following cycle if the endpoint has room for the next transfer.
- R4: `stop` while active returns the controller to idle, and `dma_req` is 0 from the next cycle on.
- R5: In single-word mode (bit 3 = 1), `dma_req` is 0 in the cycle after every `word_done`. It returns to 1 the cycle after that if transfers can continue.
- R6: In multi-word mode (bit 3 = 0), `dma_req` stays 1 across `word_done` strobes while the endpoint has room.
- R7: In free-run mode (bit 0 = 0), each `word_done` while active adds 2 to the counter. The counter updates in the cycle after the strobe.
- R8: In count-down mode (bit 0 = 1), each `word_done` subtracts 2 from the counter. A strobe at a count of 2 or less sets the counter to 0, ends the transfer and pulses `xfer_done` for one cycle. A `start` with the counter at 0 does not activate the controller and pulses `xfer_done` at once.
- R9: Without receive-limit, `dma_req` is 1 in a cycle only if `ep_room` was at least 2 bytes in the previous cycle.
- R10: With receive-limit in effect (bit 7 = 1, bit 3 = 0, bit 0 = 0, `wr_dir` = 1), `dma_req` is 0 in the cycle after `ep_room` is below 32.
- R11: Receive-limit has no effect in count-down mode, in single-word mode, or on reads (`wr_dir` = 0). In those cases the 2-byte threshold applies.
- R12: Word strobes that arrive while active but with `dma_req` low are still accepted and counted.
- R13: A counter write loads the counter only while idle. Writes during an active transfer are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration register write strobe |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration readback |
| cnt_we | input | 1 | Byte counter write strobe |
| cnt_wdata | input | 32 | Byte counter preload value |
| cnt_rdata | output | 32 | Byte counter value |
| start | input | 1 | Begin a transfer |
| stop | input | 1 | Abort or end a transfer |
| wr_dir | input | 1 | 1 = bus master writes into the endpoint, 0 = reads out of it |
| word_done | input | 1 | One 2-byte word completed on the DMA bus |
| ep_room | input | 12 | Bytes the endpoint can take (writes) or supply (reads) |
| dma_req | output | 1 | DMA request line |
| xfer_done | output | 1 | One-cycle pulse when a count-down transfer completes |

## Verification
The bench sweeps all 256 configuration write values and a range of count-down preloads from 0 to 9, odd ones included. This catches a counter that underflows on an odd remainder, or that ends one word early or late, or that never pulses done for a zero preload. It sweeps `ep_room` across both the 2-byte and the 32-byte thresholds. An off-by-one compare would show up there as a request one byte early or late. It checks every mode combination in which receive-limit must be ignored, where a wrong gating would stall a transfer that ought to run. It also sends strobes after the early drop, where a design that discards them would lose up to 16 bytes of data.

// File: rtl/dmahs_pkg.sv
package dmahs_pkg;
   localparam int unsigned CFG_W      = 8;
   localparam int unsigned CFG_BIT_RL = 7;
   localparam int unsigned CFG_BIT_SW = 3;
   localparam int unsigned CFG_BIT_CD = 0;
   localparam logic [CFG_W-1:0] CFG_IMPL_MASK =
      CFG_W'((1 << CFG_BIT_RL) | (1 << CFG_BIT_SW) | (1 << CFG_BIT_CD));

   typedef struct packed {
      logic rcv_limit;
      logic single_word;
      logic count_down;
   } dmahs_cfg_t;
endpackage

// File: rtl/dmahs_cfg_reg.sv
module dmahs_cfg_reg
   import dmahs_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [CFG_W-1:0] wdata,
   output logic [CFG_W-1:0] rdata,
   output dmahs_cfg_t       cfg
);
   logic [CFG_W-1:0] bits_q;

   for (genvar i = 0; i < CFG_W; i++) begin : g_bit
      if (CFG_IMPL_MASK[i]) begin : g_impl
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)  bits_q[i] <= 1'b0;
            else if (we) bits_q[i] <= wdata[i];
         end
      end else begin : g_rsvd
         assign bits_q[i] = 1'b0;
      end
   end

   assign rdata           = bits_q;
   assign cfg.rcv_limit   = bits_q[CFG_BIT_RL];
   assign cfg.single_word = bits_q[CFG_BIT_SW];
   assign cfg.count_down  = bits_q[CFG_BIT_CD];

   // R1
   rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> (rdata == ($past(wdata) & CFG_IMPL_MASK)));
endmodule

// File: rtl/dmahs_byte_counter.sv
module dmahs_byte_counter #(
   parameter int unsigned CNT_W      = 32,
   parameter int unsigned WORD_BYTES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_en,
   input  logic [CNT_W-1:0] load_val,
   input  logic             step,
   input  logic             count_down,
   output logic [CNT_W-1:0] cnt,
   output logic             last_word,
   output logic             is_zero
);
   localparam logic [CNT_W-1:0] STEP_V = CNT_W'(WORD_BYTES);

   if (CNT_W < 8) begin : g_bad_width
      $error("dmahs_byte_counter: CNT_W must be at least 8");
   end
   if (WORD_BYTES == 0) begin : g_bad_word
      $error("dmahs_byte_counter: WORD_BYTES must be nonzero");
   end

   logic [CNT_W-1:0] cnt_q, cnt_d;

   always_comb begin
      cnt_d = cnt_q;
      if (load_en)
         cnt_d = load_val;
      else if (step) begin
         if (count_down) cnt_d = (cnt_q > STEP_V) ? (cnt_q - STEP_V) : '0;
         else            cnt_d = cnt_q + STEP_V;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_d;
   end

   assign cnt       = cnt_q;
   assign last_word = count_down && (cnt_q <= STEP_V);
   assign is_zero   = (cnt_q == '0);

   // R8
   no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !load_en && count_down) |=> (cnt_q <= $past(cnt_q)));
endmodule

// File: rtl/dmahs_req_gen.sv
module dmahs_req_gen
   import dmahs_pkg::*;
#(
   parameter int unsigned ROOM_W     = 12,
   parameter int unsigned WORD_BYTES = 2,
   parameter int unsigned RL_THRESH  = 32,
   parameter int unsigned RL_SLACK   = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  dmahs_cfg_t        cfg,
   input  logic              start,
   input  logic              stop,
   input  logic              wr_dir,
   input  logic              word_done,
   input  logic [ROOM_W-1:0] room,
   input  logic              last_word,
   input  logic              cnt_zero,
   output logic              active,
   output logic              req,
   output logic              done
);
   localparam logic [ROOM_W-1:0] TH_NORM = ROOM_W'(WORD_BYTES);
   localparam logic [ROOM_W-1:0] TH_RL   = ROOM_W'(RL_THRESH);

   if (RL_THRESH >= (1 << ROOM_W)) begin : g_bad_thresh
      $error("dmahs_req_gen: RL_THRESH does not fit in ROOM_W");
   end
   if (RL_SLACK >= RL_THRESH || (RL_SLACK % WORD_BYTES) != 0) begin : g_bad_slack
      $error("dmahs_req_gen: RL_SLACK must be word aligned and below RL_THRESH");
   end

   logic active_q, active_d, req_q, req_d, done_q, done_d;
   logic rl_eff, can_go, zero_start;

   assign rl_eff     = cfg.rcv_limit && !cfg.single_word && !cfg.count_down && wr_dir;
   assign can_go     = room >= (rl_eff ? TH_RL : TH_NORM);
   assign zero_start = !active_q && start && cfg.count_down && cnt_zero;

   always_comb begin
      if (!active_q) active_d = start && !zero_start;
      else           active_d = !(stop || (word_done && last_word));
      done_d = zero_start || (active_q && word_done && last_word);
      req_d  = active_d && can_go && !(cfg.single_word && active_q && word_done);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         req_q    <= 1'b0;
         done_q   <= 1'b0;
      end else begin
         active_q <= active_d;
         req_q    <= req_d;
         done_q   <= done_d;
      end
   end

   assign active = active_q;
   assign req    = req_q;
   assign done   = done_q;

   // R4
   stop_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (active_q && stop) |=> (!req_q && !active_q));
   // R5
   single_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (active_q && cfg.single_word && word_done) |=> !req_q);
   // R9
   room_norm_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (room < TH_NORM) |=> !req_q);
   // R10
   rl_early_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rl_eff && room < TH_RL) |=> !req_q);
endmodule

// File: rtl/dmahs_ctrl.sv
module dmahs_ctrl
   import dmahs_pkg::*;
#(
   parameter int unsigned CNT_W      = 32,
   parameter int unsigned ROOM_W     = 12,
   parameter int unsigned WORD_BYTES = 2,
   parameter int unsigned RL_THRESH  = 32,
   parameter int unsigned RL_SLACK   = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [7:0]        cfg_wdata,
   output logic [7:0]        cfg_rdata,
   input  logic              cnt_we,
   input  logic [CNT_W-1:0]  cnt_wdata,
   output logic [CNT_W-1:0]  cnt_rdata,
   input  logic              start,
   input  logic              stop,
   input  logic              wr_dir,
   input  logic              word_done,
   input  logic [ROOM_W-1:0] ep_room,
   output logic              dma_req,
   output logic              xfer_done
);
   dmahs_cfg_t cfg;
   logic       active, last_word, cnt_zero, step, load_en;

   assign step    = word_done && active;
   assign load_en = cnt_we && !active;

   dmahs_cfg_reg u_cfg (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (cfg_we),
      .wdata (cfg_wdata),
      .rdata (cfg_rdata),
      .cfg   (cfg)
   );

   dmahs_byte_counter #(.CNT_W(CNT_W), .WORD_BYTES(WORD_BYTES)) u_cnt (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_en    (load_en),
      .load_val   (cnt_wdata),
      .step       (step),
      .count_down (cfg.count_down),
      .cnt        (cnt_rdata),
      .last_word  (last_word),
      .is_zero    (cnt_zero)
   );

   dmahs_req_gen #(
      .ROOM_W(ROOM_W), .WORD_BYTES(WORD_BYTES),
      .RL_THRESH(RL_THRESH), .RL_SLACK(RL_SLACK)
   ) u_req (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg       (cfg),
      .start     (start),
      .stop      (stop),
      .wr_dir    (wr_dir),
      .word_done (word_done),
      .room      (ep_room),
      .last_word (last_word),
      .cnt_zero  (cnt_zero),
      .active    (active),
      .req       (dma_req),
      .done      (xfer_done)
   );

   // R2
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!active && !start) |=> !dma_req);
   // R8
   done_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_done |-> (cnt_rdata == '0));
   // R7
   freerun_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (active && word_done && !cfg.count_down)
         |=> (cnt_rdata == $past(cnt_rdata) + CNT_W'(WORD_BYTES)));
   // R13
   busy_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (active && cnt_we && !word_done) |=> $stable(cnt_rdata));
endmodule

// File: tb/tb_dmahs_ctrl.sv
module tb_dmahs_ctrl;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        cfg_we, cnt_we, start, stop, wr_dir, word_done;
   logic [7:0]  cfg_wdata, cfg_rdata;
   logic [31:0] cnt_wdata, cnt_rdata;
   logic [11:0] ep_room;
   logic        dma_req, xfer_done;

   int n_chk  = 0;
   int n_fail = 0;
   bit ended  = 0;

   always #5 clk = ~clk;

   dmahs_ctrl dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
      .cfg_rdata(cfg_rdata), .cnt_we(cnt_we), .cnt_wdata(cnt_wdata),
      .cnt_rdata(cnt_rdata), .start(start), .stop(stop), .wr_dir(wr_dir),
      .word_done(word_done), .ep_room(ep_room), .dma_req(dma_req),
      .xfer_done(xfer_done)
   );

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic cyc();
      @(negedge clk);
   endtask

   task automatic set_cfg(bit rl, bit sw, bit cd);
      cfg_we = 1; cfg_wdata = {rl, 3'b000, sw, 2'b00, cd};
      cyc(); cfg_we = 0;
   endtask

   task automatic load(logic [31:0] v);
      cnt_we = 1; cnt_wdata = v;
      cyc(); cnt_we = 0;
   endtask

   task automatic go();
      start = 1; cyc(); start = 0;
   endtask

   task automatic halt();
      stop = 1; cyc(); stop = 0; cyc();
   endtask

   initial begin
      #2_000_000;
      if (!ended) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      rst_n = 0; cfg_we = 0; cfg_wdata = 0; cnt_we = 0; cnt_wdata = 0;
      start = 0; stop = 0; wr_dir = 1; word_done = 0; ep_room = 64;
      cyc(); cyc();
      chk("R1 cfg reset", cfg_rdata, 0);
      chk("R2 req reset", dma_req, 0);
      chk("R2 done reset", xfer_done, 0);
      chk("R2 cnt reset", cnt_rdata, 0);
      rst_n = 1; cyc();

      // R1 exhaustive register sweep
      for (int v = 0; v < 256; v++) begin
         cfg_we = 1; cfg_wdata = 8'(v); cyc(); cfg_we = 0;
         chk("R1 cfg readback", cfg_rdata, 32'(v & 8'h89));
      end

      // R2 / R13 idle behaviour
      set_cfg(0, 0, 0);
      load(100);
      chk("R13 idle load", cnt_rdata, 100);
      word_done = 1; cyc(); word_done = 0;
      chk("R2 idle strobe ignored", cnt_rdata, 100);
      chk("R2 idle no req", dma_req, 0);

      // R3 R6 R7 free-run multi-word
      load(0); ep_room = 64; wr_dir = 1;
      go();
      chk("R3 req after start", dma_req, 1);
      for (int k = 1; k <= 20; k++) begin
         word_done = 1; cyc();
         chk("R6 multi-word held", dma_req, 1);
         chk("R7 free-run count", cnt_rdata, 32'(2 * k));
      end
      word_done = 0;
      cnt_we = 1; cnt_wdata = 999; cyc(); cnt_we = 0;
      chk("R13 busy load ignored", cnt_rdata, 40);
      stop = 1; cyc(); stop = 0;
      chk("R4 stop drops req", dma_req, 0);
      cyc();
      chk("R4 stays idle", dma_req, 0);
      chk("R4 count kept", cnt_rdata, 40);

      // R9 room sweep across the word threshold
      go();
      for (int r = 0; r <= 6; r++) begin
         ep_room = 12'(r); cyc();
         chk("R9 room threshold", dma_req, 32'(r >= 2));
      end
      ep_room = 64; halt();

      // R5 single-word
      set_cfg(0, 1, 0); load(0); go();
      chk("R5 req after start", dma_req, 1);
      for (int k = 1; k <= 6; k++) begin
         word_done = 1; cyc(); word_done = 0;
         chk("R5 gap after word", dma_req, 0);
         cyc();
         chk("R5 req returns", dma_req, 1);
      end
      halt();

      // R8 count-down preload sweep
      set_cfg(0, 0, 1);
      for (int v = 0; v <= 9; v++) begin
         load(32'(v)); go();
         if (v == 0) begin
            chk("R8 zero start done", xfer_done, 1);
            chk("R8 zero start no req", dma_req, 0);
         end else begin
            chk("R8 no early done", xfer_done, 0);
            chk("R8 req active", dma_req, 1);
            for (int w = 1; w <= (v + 1) / 2; w++) begin
               word_done = 1; cyc();
               chk("R8 remaining", cnt_rdata, 32'((v > 2 * w) ? v - 2 * w : 0));
               chk("R8 done pulse", xfer_done, 32'(w == (v + 1) / 2));
               chk("R8 req at end", dma_req, 32'(w != (v + 1) / 2));
            end
            word_done = 0;
         end
         cyc();
         chk("R8 done one cycle", xfer_done, 0);
      end

      // R10 R12 receive-limit
      set_cfg(1, 0, 0); wr_dir = 1; load(0); ep_room = 40; go();
      chk("R10 req above limit", dma_req, 1);
      ep_room = 32; cyc();
      chk("R10 req at limit", dma_req, 1);
      ep_room = 31; cyc();
      chk("R10 early drop", dma_req, 0);
      for (int k = 1; k <= 8; k++) begin
         word_done = 1; cyc();
         chk("R12 late word counted", cnt_rdata, 32'(2 * k));
         chk("R12 req stays low", dma_req, 0);
      end
      word_done = 0; ep_room = 40; cyc();
      chk("R10 req resumes", dma_req, 1);
      halt();

      // R11 receive-limit ignored in other combinations
      ep_room = 20;
      set_cfg(1, 0, 1); wr_dir = 1; load(1000); go();
      chk("R11 ignored count-down", dma_req, 1);
      halt();
      set_cfg(1, 1, 0); wr_dir = 1; load(0); go();
      chk("R11 ignored single-word", dma_req, 1);
      halt();
      set_cfg(1, 0, 0); wr_dir = 0; go();
      chk("R11 ignored on read", dma_req, 1);
      halt();

      ended = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule